// File: doc/BRIEF.md
# Indexed Multi-Channel Clock-Enable Controller

The block drives up to five clock channels from one programming register. Each channel picks one of several source enable streams, divides that stream by a power of two (or by three through a spare divider code), and can be switched on or off. Each channel's output is a stream of single-cycle enable pulses, not a real clock. Everything runs in one system clock domain.

Software reaches all channels through a single indirect control word. A write with the command bit clear only selects a channel, and reads then return that channel's settings. A write with the command bit set loads new settings into the channel named in the same word. A two-bit status output shows whether channels have settled after a source switch. One bit covers channel 0 and the other is shared by all remaining channels. A channel that is switching source holds its output low. It becomes ready again after a fixed number of pulses of its new source.

Top module: `clkch_ctrl`

## Requirements
- R1: After reset every channel is off with source 0 and divider code 0, the selected ID is 0, `rd_data` reads 0, both `status` bits are 1 and no `ch_pulse` bit is ever high until a channel is enabled.
- R2: A write with `wr_data[7]`=0 only latches the ID in `wr_data[3:0]`; no channel setting changes. `rd_data` then shows the selected channel: ID at bits 3:0, divider code at 10:8, source at 16+SRC_W-1:16, enable at 28, all other bits 0.
- R3: A write with `wr_data[7]`=1 and a valid ID loads enable (bit 28), source (bits 16 up) and divider code (bits 10:8) into that channel and also selects it.
- R4: A write with `wr_data[7]`=1 naming an ID of NUM_CH or above changes no channel and does not change the selected ID.
- R5: For divider code n in 0..6 an enabled, ready channel emits exactly one pulse for every 2^n pulses of its selected source. Each pulse appears one cycle after the source pulse that completes the count.
- R6: With DIV3_EN set, code 7 divides by 3; with it clear, code 7 divides by 128.
- R7: `status[0]` is channel 0's ready flag; `status[1]` is the AND of the ready flags of channels 1 and up.
- R8: A channel's ready flag is cleared only by a command write whose source differs from the channel's current source; changing only divider or enable leaves it set.
- R9: After a source change, ready returns on the SETTLE-th pulse (default 4) of the new source, and pulses of other sources do not count. The channel emits no pulse while it is not ready.
- R10: A disabled channel emits no pulses. The divide counter restarts from zero when the channel is enabled, when its divider code changes, or when its source changes.
- R11: A channel counts only pulses on `src_en[source]`; pulses on other sources never produce output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word written |
| rd_data | output | 32 | Settings of the selected channel |
| status | output | 2 | Ready flags: bit 0 channel 0, bit 1 all others |
| src_en | input | 2**SRC_W | Source enable streams, one bit per source |
| ch_pulse | output | NUM_CH | Divided enable pulse per channel |

## Verification
A wrong divide counter shows on `ch_pulse` as a miscounted pulse total within one divide period, at most 128 source pulses. A counter that keeps its old value when it should restart shows on the first pulse after a divider or enable write. A stuck or mis-cleared ready flag shows on `status` directly after the command write, or on the SETTLE-th pulse of the new source. A wrong latched ID or channel setting shows on `rd_data` on the cycle after the write.

// File: rtl/clkch_pkg.sv
// Package: control word field positions and the divide ratio decode.
// Assumes a 32-bit control word; source field must end below the enable bit.
package clkch_pkg;
    localparam int REG_W   = 32;
    localparam int ID_LSB  = 0;
    localparam int ID_W    = 4;
    localparam int CMD_BIT = 7;
    localparam int DIV_LSB = 8;
    localparam int DIV_W   = 3;
    localparam int SRC_LSB = 16;
    localparam int EN_BIT  = 28;
    localparam int RAT_W   = 2 ** DIV_W;   // wide enough for 2^(2^DIV_W - 1)

    // Divide ratio for a divider code; the top code may mean three.
    function automatic logic [RAT_W-1:0] div_ratio(input logic [DIV_W-1:0] code,
                                                   input logic div3);
        if (div3 && (code == {DIV_W{1'b1}}))
            return RAT_W'(3);
        return RAT_W'(1) << code;
    endfunction
endpackage

// File: rtl/clkch_regif.sv
// Register interface: decodes writes of the control word into per-channel
// load strobes, keeps the selected channel ID and builds the read word.
// Assumes NUM_CH <= 2^ID_W and fields laid out as in clkch_pkg.
module clkch_regif
    import clkch_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int SRC_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH*SRC_W-1:0] ch_src,
    input  logic [NUM_CH*DIV_W-1:0] ch_div,
    output logic [NUM_CH-1:0]       load,
    output logic                    f_en,
    output logic [SRC_W-1:0]        f_src,
    output logic [DIV_W-1:0]        f_div,
    output logic [REG_W-1:0]        rd_data
);
    logic [ID_W-1:0] sel_q;
    logic [ID_W-1:0] f_id;
    logic            f_cmd;
    logic            id_ok;

    assign f_id  = wr_data[ID_LSB +: ID_W];
    assign f_cmd = wr_data[CMD_BIT];
    assign f_en  = wr_data[EN_BIT];
    assign f_src = wr_data[SRC_LSB +: SRC_W];
    assign f_div = wr_data[DIV_LSB +: DIV_W];
    assign id_ok = (32'(f_id) < NUM_CH);

    // Load strobe for the channel named by a valid command write.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            load[i] = wr_en && f_cmd && (f_id == ID_W'(i));
    end

    // Latch the selected ID on select writes and on valid command writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en && (!f_cmd || id_ok))
            sel_q <= f_id;
    end

    // Read word: selected ID plus the settings of that channel.
    always_comb begin
        rd_data = '0;
        rd_data[ID_LSB +: ID_W] = sel_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_q == ID_W'(i)) begin
                rd_data[EN_BIT]              = ch_en[i];
                rd_data[SRC_LSB +: SRC_W]    = ch_src[i*SRC_W +: SRC_W];
                rd_data[DIV_LSB +: DIV_W]    = ch_div[i*DIV_W +: DIV_W];
            end
        end
    end

    // R4: a command write with an out-of-range ID keeps the selection
    p_bad_id_keeps_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && f_cmd && !id_ok) |=> $stable(sel_q));
endmodule

// File: rtl/clkch_channel.sv
// One clock channel: holds enable, source and divider code, divides the
// selected source enable stream and tracks readiness after a source switch.
// Assumes SETTLE >= 1; the load strobe has priority over counting.
module clkch_channel
    import clkch_pkg::*;
#(
    parameter int SRC_W   = 5,
    parameter bit DIV3_EN = 1'b1,
    parameter int SETTLE  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 f_en,
    input  logic [SRC_W-1:0]     f_src,
    input  logic [DIV_W-1:0]     f_div,
    input  logic [2**SRC_W-1:0]  src_en,
    output logic                 en_o,
    output logic [SRC_W-1:0]     src_o,
    output logic [DIV_W-1:0]     div_o,
    output logic                 ready_o,
    output logic                 pulse_o
);
    localparam int CNT_W = RAT_W - 1;
    localparam int ST_W  = $clog2(SETTLE + 1);

    logic             en_q;
    logic [SRC_W-1:0] src_q;
    logic [DIV_W-1:0] div_q;
    logic             rdy_q;
    logic [ST_W-1:0]  settle_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             tick;
    logic             last;
    logic [RAT_W-1:0] ratio;

    assign tick  = src_en[src_q];
    assign ratio = div_ratio(div_q, DIV3_EN);
    assign last  = ({1'b0, cnt_q} == (ratio - RAT_W'(1)));

    // Settings, readiness, settle countdown and divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            src_q    <= '0;
            div_q    <= '0;
            rdy_q    <= 1'b1;
            settle_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            en_q  <= f_en;
            src_q <= f_src;
            div_q <= f_div;
            if (f_src != src_q) begin
                rdy_q    <= 1'b0;
                settle_q <= ST_W'(SETTLE);
                cnt_q    <= '0;
            end else if ((f_en && !en_q) || (f_div != div_q)) begin
                cnt_q <= '0;
            end
        end else if (!rdy_q) begin
            if (tick) begin
                if (settle_q == ST_W'(1))
                    rdy_q <= 1'b1;
                settle_q <= settle_q - 1'b1;
            end
        end else if (en_q && tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // Registered output pulse on the source pulse that completes a period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= !load && en_q && rdy_q && tick && last;
    end

    assign en_o    = en_q;
    assign src_o   = src_q;
    assign div_o   = div_q;
    assign ready_o = rdy_q;
    assign pulse_o = pulse_q;

    // R10: no pulse follows a cycle in which the channel was disabled
    p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !pulse_q);
    // R9: no pulse follows a cycle in which the channel was switching
    p_switch_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_q |=> !pulse_q);
    // R11: every pulse is caused by a pulse of the selected source
    p_pulse_from_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(tick));
    // R8: readiness drops only on a load that changes the source
    p_drop_on_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_q) |-> $past(load && (f_src != src_q)));
    // R5: the divide counter stays below the ratio
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < ratio));
endmodule

// File: rtl/clkch_ctrl.sv
// Top: register interface plus NUM_CH clock channels and the status word.
// Assumes 2 <= NUM_CH <= 16 and SRC_LSB + SRC_W <= EN_BIT.
module clkch_ctrl
    import clkch_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int SRC_W   = 5,
    parameter bit DIV3_EN = 1'b1,
    parameter int SETTLE  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [1:0]          status,
    input  logic [2**SRC_W-1:0] src_en,
    output logic [NUM_CH-1:0]   ch_pulse
);
    logic [NUM_CH-1:0]       load;
    logic                    f_en;
    logic [SRC_W-1:0]        f_src;
    logic [DIV_W-1:0]        f_div;
    logic [NUM_CH-1:0]       ch_en;
    logic [NUM_CH*SRC_W-1:0] ch_src;
    logic [NUM_CH*DIV_W-1:0] ch_div;
    logic [NUM_CH-1:0]       ch_rdy;

    clkch_regif #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ch_en(ch_en), .ch_src(ch_src), .ch_div(ch_div),
        .load(load), .f_en(f_en), .f_src(f_src), .f_div(f_div),
        .rd_data(rd_data)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkch_channel #(.SRC_W(SRC_W), .DIV3_EN(DIV3_EN), .SETTLE(SETTLE)) u_ch (
            .clk(clk), .rst_n(rst_n), .load(load[i]),
            .f_en(f_en), .f_src(f_src), .f_div(f_div), .src_en(src_en),
            .en_o(ch_en[i]), .src_o(ch_src[i*SRC_W +: SRC_W]),
            .div_o(ch_div[i*DIV_W +: DIV_W]),
            .ready_o(ch_rdy[i]), .pulse_o(ch_pulse[i])
        );
    end

    // Status: channel 0 alone, then all other channels combined.
    assign status = {&ch_rdy[NUM_CH-1:1], ch_rdy[0]};

    // R7: a shared status bit of one means every other channel is ready
    p_shared_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> ($countones(ch_rdy[NUM_CH-1:1]) == NUM_CH - 1));
endmodule

// File: tb/clkch_ctrl_test.sv
module clkch_ctrl_test;
    localparam int NCH = 5;
    localparam int SW  = 5;
    localparam int NSRC = 2 ** SW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [1:0]      status;
    logic [NSRC-1:0] src_en = '0;
    logic [NCH-1:0]  ch_pulse;

    int errors = 0;
    int checks = 0;
    int pc [NCH];
    int snap [NCH];
    bit done = 1'b0;

    clkch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .status(status), .src_en(src_en), .ch_pulse(ch_pulse)
    );

    always #5 clk = ~clk;

    initial for (int c = 0; c < NCH; c++) pc[c] = 0;

    // Pulse counters, sampled 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        for (int c = 0; c < NCH; c++) pc[c] += int'(ch_pulse[c]);
    end

    function automatic logic [31:0] word(int id, bit cmd, bit en, int src, int dv);
        logic [31:0] w = '0;
        w[3:0]   = 4'(id);
        w[7]     = cmd;
        w[10:8]  = 3'(dv);
        w[20:16] = 5'(src);
        w[28]    = en;
        return w;
    endfunction

    function automatic int ratio(int dv);
        return (dv == 7) ? 3 : (1 << dv);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int id, bit cmd, bit en, int src, int dv);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = word(id, cmd, en, src, dv);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Drive n cycles of the source mask, then idle; pulses land in snap deltas.
    task automatic ticks(logic [NSRC-1:0] mask, int n);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) snap[c] = pc[c];
        for (int i = 0; i < n; i++) begin
            src_en = mask;
            @(negedge clk);
        end
        src_en = '0;
        @(negedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) snap[c] = pc[c] - snap[c];
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "status", status, 2'b11);
        ticks('1, 20);
        for (int c = 0; c < NCH; c++) chk("R1", "no pulse while off", snap[c], 0);

        // R4: command writes naming IDs above the channel range
        wr(2, 1'b0, 1'b0, 0, 0);
        for (int id = NCH; id < 16; id++) wr(id, 1'b1, 1'b1, 7, 1);
        chk("R4", "selection kept", rd_data, word(2, 0, 0, 0, 0));
        chk("R4", "status kept", status, 2'b11);
        ticks('1, 20);
        for (int c = 0; c < NCH; c++) chk("R4", "no channel enabled", snap[c], 0);
        for (int c = 0; c < NCH; c++) begin
            wr(c, 1'b0, 1'b0, 0, 0);
            chk("R4", "channel untouched", rd_data, word(c, 0, 0, 0, 0));
        end

        // R5 / R6: every channel, every divider code, source 0
        for (int c = 0; c < NCH; c++) begin
            for (int dv = 0; dv < 8; dv++) begin
                wr(c, 1'b1, 1'b0, 0, dv);
                wr(c, 1'b1, 1'b1, 0, dv);
                ticks('1, 192);
                chk(dv == 7 ? "R6" : "R5", "pulse count", snap[c], 192 / ratio(dv));
                for (int o = 0; o < NCH; o++)
                    if (o != c) chk("R10", "other channel silent", snap[o], 0);
                wr(c, 1'b1, 1'b0, 0, dv);
            end
        end
        chk("R8", "no source change keeps ready", status, 2'b11);

        // R10: divider change restarts the counter
        wr(3, 1'b1, 1'b1, 0, 2);
        ticks('1, 2);
        wr(3, 1'b1, 1'b1, 0, 1);
        ticks('1, 2);
        chk("R10", "restart on divider change", snap[3], 1);
        // R10: re-enable restarts the counter
        wr(3, 1'b1, 1'b1, 0, 2);
        wr(3, 1'b1, 1'b0, 0, 2);
        wr(3, 1'b1, 1'b1, 0, 2);
        ticks('1, 3);
        wr(3, 1'b1, 1'b0, 0, 2);
        ticks('1, 8);
        chk("R10", "disabled stays silent", snap[3], 0);
        wr(3, 1'b1, 1'b1, 0, 2);
        ticks('1, 3);
        chk("R10", "restart on enable", snap[3], 0);
        ticks('1, 1);
        chk("R10", "fourth tick pulses", snap[3], 1);
        wr(3, 1'b1, 1'b0, 0, 2);

        // R9 / R7: source switch on channel 2 to source 3
        wr(2, 1'b1, 1'b1, 3, 0);
        chk("R7", "shared ready drops", status, 2'b01);
        ticks(32'h1, 6);
        chk("R9", "other source does not settle", status, 2'b01);
        chk("R9", "held low on other source", snap[2], 0);
        ticks(32'h8, 3);
        chk("R9", "not ready after SETTLE-1", status, 2'b01);
        chk("R9", "held low while switching", snap[2], 0);
        ticks(32'h8, 1);
        chk("R9", "ready after SETTLE", status, 2'b11);
        chk("R9", "settling tick gives no pulse", snap[2], 0);
        ticks(32'h8, 6);
        chk("R5", "new source divide by 1", snap[2], 6);
        // R11: other sources do not drive channel 2
        ticks(~32'h8, 10);
        chk("R11", "unselected sources ignored", snap[2], 0);

        // R8: divider-only and enable-only changes keep ready
        wr(2, 1'b1, 1'b1, 3, 2);
        chk("R8", "divider change keeps ready", status, 2'b11);
        wr(2, 1'b1, 1'b0, 3, 2);
        chk("R8", "enable change keeps ready", status, 2'b11);
        wr(0, 1'b1, 1'b1, 1, 0);
        chk("R7", "channel 0 bit alone", status, 2'b10);
        ticks(32'h2, 4);
        chk("R7", "channel 0 ready again", status, 2'b11);

        // R3 / R2: load and read back
        wr(1, 1'b1, 1'b1, 5, 3);
        chk("R3", "command selects and loads", rd_data, word(1, 0, 1, 5, 3));
        wr(4, 1'b1, 1'b1, 31, 7);
        chk("R3", "load max fields", rd_data, word(4, 0, 1, 31, 7));
        wr(0, 1'b0, 1'b0, 0, 0);
        chk("R2", "read channel 0", rd_data, word(0, 0, 1, 1, 0));
        wr(1, 1'b0, 1'b0, 9, 6);
        chk("R2", "select-only ignores fields", rd_data, word(1, 0, 1, 5, 3));
        wr(2, 1'b0, 1'b1, 0, 0);
        chk("R2", "read channel 2", rd_data, word(2, 0, 0, 3, 2));
        wr(3, 1'b0, 1'b0, 0, 0);
        chk("R2", "read channel 3", rd_data, word(3, 0, 0, 0, 2));
        wr(12, 1'b0, 1'b0, 0, 0);
        chk("R2", "invalid selection reads ID only", rd_data, word(12, 0, 0, 0, 0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule